// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that a processor reaches through a small byte-wide register bus. Software places the count by writing its low and high bytes one at a time. It reads them back the same way. It also writes a control byte that turns counting on or off, chooses the count source and sets the prescale ratio.

The count source is one of two:
- an internal tick, one pulse every fourth system clock, which matches an instruction-rate timebase;
- rising edges on an external clock pin.

External edges can pass through a two-flop synchronizer before edge detection. They can also be caught by a single capture flop, which is the fast asynchronous path. Either source then goes through a divide-by-1/2/4/8 prescaler before it reaches the counter.

When the count wraps from all ones to zero, a sticky overflow flag is set. The interrupt line is high while that flag and an enable bit are both set. A trigger input from a compare unit forces the count to zero.

Top module: `tmr16_ctr`

## Requirements
- R1: After reset the count is 0x0000, the control byte (address 2) is 0, the overflow flag and interrupt enable are 0, and irq is low.
- R2: A write to address 0 loads the low count byte. A write to address 1 loads the high count byte. The other byte is unchanged. A read of address 0 or 1 returns that byte of the current count in the same cycle.
- R3: Address 3 holds the overflow flag in bit 0 and the interrupt enable in bit 1. An increment from 0xFFFF gives 0x0000 and sets the flag. The flag stays set until software writes 0 to bit 0. If a wrap and that write fall in the same cycle, the flag is set. irq is high exactly while flag and enable are both 1.
- R4: Control bit 0 is run. While it is 0 the count holds, unless a byte write or the trigger changes it.
- R5: Control bit 1 selects the source: 0 for the internal tick, 1 for the external pin. The internal tick fires on every fourth system clock, counted from reset release: the fourth, eighth, and so on. With the internal source, the pin and control bit 2 have no effect.
- R6: Control bits [4:3] set the prescale ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8 source events per count.
- R7: Control bit 2 = 1 (synchronized) with the external source: a rising pin edge raises the count 2 to 3 clocks after the pin changes.
- R8: Control bit 2 = 0 (asynchronous) with the external source: a rising pin edge is caught by one capture flop and raises the count 1 to 2 clocks after the pin changes.
- R9: A high trigger input clears the count to 0x0000 on the next clock. It wins over a byte write in the same cycle. It never sets the overflow flag.
- R10: A count byte write in the same cycle as an increment wins; the increment is lost. Any count byte write also restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 low byte, 1 high byte, 2 control, 3 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_clk | input | 1 | External count clock pin |
| trig_clr | input | 1 | Special-event clear from a compare unit |
| irq | output | 1 | Overflow interrupt request |

## Verification
Internal-tick counting is run at all four prescale ratios, with the synchronize bit set and cleared. This separates a wrong tick phase or ratio decode from a source mux that wrongly looks at the synchronize bit. External pulses are fed through both the synchronized and the single-flop paths. The per-clock comparison against the reference model then shows the one-cycle latency difference between them, and would catch a path that counts edges twice. Directed collisions are also driven: writes during increments, the trigger together with a write, and a wrap from 0xFFF0 with the enable set and then cleared. These expose wrong priority, a lost prescaler restart, or a flag that is not sticky.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [1:0] A_CNT_LO = 2'd0;
  localparam logic [1:0] A_CNT_HI = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;

  // bit 0 run, bit 1 source, bit 2 synchronize, bits [4:3] prescale
  typedef struct packed {
    logic [1:0] ps;
    logic       sync;
    logic       src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [TW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                         phase_q <= '0;
    else if (phase_q == TW'(DIV-1))  phase_q <= '0;
    else                             phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == TW'(DIV-1));
endmodule

// File: rtl/tmr16_edge_in.sv
module tmr16_edge_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic sync_en,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  logic rise_sync, rise_fast;
  assign rise_sync = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign rise_fast = sh_q[0] & ~sh_q[1];
  assign rise      = sync_en ? rise_sync : rise_fast;
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            ev,
  input  logic [PS_W-1:0] ps,
  output logic            inc
);
  localparam int PC_W = (1 << PS_W) - 1;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;
  logic            full;

  assign mask = (PC_W'(1) << ps) - PC_W'(1);
  assign full = (pc_q >= mask);
  assign inc  = ev & full;

  always_ff @(posedge clk) begin
    if (rst || restart) pc_q <= '0;
    else if (ev)        pc_q <= full ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_ctr.sv
module tmr16_ctr #(
  parameter int DATA_W      = 8,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PS_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic              trig_clr,
  output logic              irq
);
  import tmr16_pkg::*;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, ie_q;
  logic             tick, ext_rise, ev, inc, ovf_evt;
  logic             wr_lo, wr_hi, wr_cnt, wr_ctl, wr_st;

  assign wr_lo  = bus_wr_en && (bus_addr == A_CNT_LO);
  assign wr_hi  = bus_wr_en && (bus_addr == A_CNT_HI);
  assign wr_ctl = bus_wr_en && (bus_addr == A_CTRL);
  assign wr_st  = bus_wr_en && (bus_addr == A_STAT);
  assign wr_cnt = wr_lo | wr_hi;

  tmr16_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  tmr16_edge_in #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin(ext_clk), .sync_en(ctrl_q.sync), .rise(ext_rise)
  );

  assign ev = ctrl_q.run & (ctrl_q.src ? ext_rise : tick);

  tmr16_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_cnt), .ev(ev), .ps(ctrl_q.ps), .inc(inc)
  );

  assign ovf_evt = inc && !trig_clr && !wr_cnt && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (trig_clr)   cnt_q <= '0;
      else if (wr_lo) cnt_q[DATA_W-1:0] <= bus_wdata;
      else if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= bus_wdata;
      else if (inc)   cnt_q <= cnt_q + 1'b1;

      if (ovf_evt)    ovf_q <= 1'b1;
      else if (wr_st) ovf_q <= bus_wdata[0];

      if (wr_st)  ie_q   <= bus_wdata[1];
      if (wr_ctl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
      A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
      A_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:  bus_rdata = {{(DATA_W-2){1'b0}}, ie_q, ovf_q};
    endcase
  end

  assign irq = ovf_q & ie_q;
endmodule

// File: rtl/tmr16_ctr_chk.sv
module tmr16_ctr_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  count,
  input logic              flag,
  input logic              run
);
  logic wr_cnt;
  assign wr_cnt = wr_en && (addr == 2'd0 || addr == 2'd1);

  // R9
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (count == '0));

  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !trig && !wr_cnt) |=> $stable(count));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && addr == 2'd3 && !wdata[0])) |=> flag);

  // R3
  flag_from_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && !$past(wr_en && addr == 2'd3 && wdata[0])) |-> ($past(count) == '1));

  // R2
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && !trig) |=> (count[DATA_W-1:0] == $past(wdata)));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig && !wr_cnt) |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

bind tmr16_ctr tmr16_ctr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig_clr), .wr_en(bus_wr_en), .addr(bus_addr),
  .wdata(bus_wdata), .count(cnt_q), .flag(ovf_q), .run(ctrl_q.run)
);

// File: tb/tmr16_ctr_bench.sv
`timescale 1ns/1ps
module tmr16_ctr_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       trig_clr = 1'b0;
  logic       irq;

  tmr16_ctr u_tmr16_ctr (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .trig_clr(trig_clr), .irq(irq)
  );

  always #5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_flag, m_ie, m_run, m_src, m_sync, m_ps, m_pre, m_ph;
  bit m_pin[$];

  always @(posedge clk) begin
    int  tick, rise, ev, inc, wlo, whi, wst, wct, mask, top;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_ie = 0; m_run = 0; m_src = 0; m_sync = 0;
      m_ps = 0; m_pre = 0; m_ph = 0;
      m_pin = '{0, 0, 0};
    end else begin
      tick = (m_ph == 3);
      m_ph = (m_ph + 1) % 4;
      // m_pin[0] newest capture, [1] older, [2] oldest
      rise = m_sync ? (m_pin[1] && !m_pin[2]) : (m_pin[0] && !m_pin[1]);
      m_pin.push_front(ext_clk);
      void'(m_pin.pop_back());
      wlo = bus_wr_en && bus_addr == 0;
      whi = bus_wr_en && bus_addr == 1;
      wct = bus_wr_en && bus_addr == 2;
      wst = bus_wr_en && bus_addr == 3;
      ev = m_run && (m_src ? rise : tick);
      mask = (1 << m_ps) - 1;
      inc = ev && (m_pre >= mask);
      if (wlo || whi) m_pre = 0;
      else if (ev) m_pre = inc ? 0 : m_pre + 1;
      top = 0;
      if (trig_clr) m_cnt = 0;
      else if (wlo) m_cnt = (m_cnt & 16'hFF00) | bus_wdata;
      else if (whi) m_cnt = (m_cnt & 16'h00FF) | (bus_wdata << 8);
      else if (inc) begin
        top = (m_cnt == 16'hFFFF);
        m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      if (top) m_flag = 1;
      else if (wst) m_flag = bus_wdata[0];
      if (wst) m_ie = bus_wdata[1];
      if (wct) begin
        m_run = bus_wdata[0]; m_src = bus_wdata[1]; m_sync = bus_wdata[2];
        m_ps = bus_wdata[4:3];
      end
    end
  end

  function automatic int exp_rdata();
    case (bus_addr)
      2'd0: return m_cnt & 8'hFF;
      2'd1: return (m_cnt >> 8) & 8'hFF;
      2'd2: return (m_ps << 3) | (m_sync << 2) | (m_src << 1) | m_run;
      default: return (m_ie << 1) | m_flag;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (int'(bus_rdata) != exp_rdata()) begin
        n_fail++;
        $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h", cur_req, bus_addr,
                 bus_rdata, exp_rdata());
      end
      n_tests++;
      if (int'(irq) != (m_flag & m_ie)) begin
        n_fail++;
        $display("FAIL %s irq actual=%0d expected=%0d", cur_req, irq, m_flag & m_ie);
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr_en = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic pulses(int n, int half);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; cyc(half);
      ext_clk = 1'b0; cyc(half);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1"; cyc(4); rst = 1'b0;
    bus_addr = 2'd2; cyc(); bus_addr = 2'd3; cyc(); bus_addr = 2'd1; cyc();
    bus_addr = 2'd0; cyc(2);

    cur_req = "R2";
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    bus_addr = 2'd1; cyc(2); bus_addr = 2'd0; cyc(2);

    cur_req = "R5";
    wr(2'd2, 8'h01); cyc(20);
    wr(2'd2, 8'h05); pulses(4, 3);

    cur_req = "R6";
    wr(2'd2, 8'h09); cyc(40);
    wr(2'd2, 8'h11); cyc(40);
    wr(2'd2, 8'h19); bus_addr = 2'd0; cyc(70);

    cur_req = "R4";
    wr(2'd2, 8'h00); cyc(12);
    wr(2'd2, 8'h02); pulses(4, 3);

    cur_req = "R3";
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF); wr(2'd3, 8'h02); wr(2'd2, 8'h01);
    cyc(80); bus_addr = 2'd3; cyc(3); bus_addr = 2'd0;
    wr(2'd3, 8'h00); cyc(3);
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF); cyc(20); wr(2'd3, 8'h02);
    bus_addr = 2'd3; cyc(3); bus_addr = 2'd0;
    wr(2'd3, 8'h02); cyc(3);

    cur_req = "R7";
    wr(2'd2, 8'h07); pulses(8, 3);
    wr(2'd2, 8'h0F); pulses(8, 2);

    cur_req = "R8";
    wr(2'd2, 8'h03); pulses(8, 2);
    wr(2'd2, 8'h13); pulses(10, 3);

    cur_req = "R9";
    wr(2'd2, 8'h01); cyc(10);
    trig_clr = 1'b1; cyc(); trig_clr = 1'b0; cyc(5);
    wr(2'd1, 8'hAB);
    trig_clr = 1'b1; bus_wr_en = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h55;
    cyc(); trig_clr = 1'b0; bus_wr_en = 1'b0;
    bus_addr = 2'd1; cyc(3); bus_addr = 2'd0;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'h03);
    ext_clk = 1'b1; cyc(); trig_clr = 1'b1; cyc(); trig_clr = 1'b0;
    ext_clk = 1'b0; bus_addr = 2'd3; cyc(3); bus_addr = 2'd0;

    cur_req = "R10";
    wr(2'd2, 8'h01);
    for (int i = 0; i < 8; i++) wr(2'd0, 8'(i * 3));
    wr(2'd2, 8'h19); cyc(15);
    for (int i = 0; i < 4; i++) begin
      wr(2'd1, 8'(i)); cyc(9);
    end
    wr(2'd2, 8'h1F); pulses(5, 2); wr(2'd0, 8'h00); pulses(12, 2);
    bus_addr = 2'd1; cyc(2);

    finish_run();
  end
endmodule